// File: doc/BRIEF.md
# Register and ALU Execution Slice

This block joins a two-read, one-write integer register file to a combinational arithmetic unit, so that register-register and register-immediate operations can be executed one per clock by driving the control inputs directly. Operand A always comes from the first read port. Operand B comes from either the second read port or a 64-bit immediate input. The unit's result always feeds the write port, and it commits on the rising clock edge when the write enable is high.

Register 0 reads as zero and ignores writes. A synchronous clear zeroes every register, and an active-low asynchronous reset does the same at power-up. Registers 5 and 6 are always visible on two observation outputs. A load-immediate is done as an add of the immediate to register 0, with the immediate selected as operand B.

Top module: `regalu_datapath`

## Requirements
- R1: While rst_ni is low, and after it is released with no write, both observation outputs read 0. Asserting rst_ni low clears the registers without waiting for a clock edge.
- R2: On a rising edge with wr_en_i=1 and clr_i=0, the register named by wr_sel_i takes the unit's result. With op_i=0 (add), the result is operand A plus operand B, modulo 2^64.
- R3: When b_imm_sel_i=0, operand B is the value of the register named by rd_b_sel_i. When b_imm_sel_i=1, operand B is imm_i.
- R4: op_i=1 gives operand A minus operand B, modulo 2^64.
- R5: op_i=2 gives the low 64 bits of operand A times operand B.
- R6: op_i=3 shifts operand A left, and op_i=4 shifts it right logically (zero fill). The shift amount is operand B bits [5:0], and the upper bits of operand B are ignored.
- R7: With wr_en_i=0 and clr_i=0, a clock edge changes no register.
- R8: Register 0 always reads 0 on either read port. A write addressed to register 0 is discarded.
- R9: On a rising edge with clr_i=1, every register becomes 0. This holds even when wr_en_i=1 in the same cycle.
- R10: obs_t0_o shows the stored value of register 5 and obs_t1_o shows the stored value of register 6. Writes to other registers leave both outputs unchanged.
- R11: op_i values 5, 6 and 7 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all registers |
| rd_a_sel_i | input | 5 | Register index for operand A |
| rd_b_sel_i | input | 5 | Register index for the second read port |
| wr_sel_i | input | 5 | Destination register index |
| wr_en_i | input | 1 | Write enable |
| b_imm_sel_i | input | 1 | Operand B source: 0 register, 1 immediate |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 mul, 3 sll, 4 srl |
| imm_i | input | 64 | Immediate operand |
| obs_t0_o | output | 64 | Current value of register 5 |
| obs_t1_o | output | 64 | Current value of register 6 |

## Verification
Short instruction sequences are replayed one per clock, and both observation outputs are checked after each edge. Adds by immediate from a cleared register catch carry and sign-extension errors, because an add of minus one must give all ones. A subtract with both operands taken from registers proves that the second read port, and not the immediate, reaches operand B. A signed-looking multiply, and shifts by amounts of 63 and 65, separate truncation, zero fill and six-bit masking. Writes to register 0, writes with the enable low, a clear that coincides with a write, and an undefined operation code each probe a path where nothing, or zero, must be stored.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_SLL = 3'd3,
    OP_SRL = 3'd4
  } alu_op_e;
endpackage

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int OBS0  = 5,
  parameter int OBS1  = 6,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [AW-1:0]   rd_a_sel_i,
  input  logic [AW-1:0]   rd_b_sel_i,
  input  logic [AW-1:0]   wr_sel_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o,
  output logic [XLEN-1:0] obs0_o,
  output logic [XLEN-1:0] obs1_o
);
  logic [XLEN-1:0]  regs_w [NREGS];
  logic [NREGS-1:0] wr_hot;

  // index 0 is a constant, never stored
  assign regs_w[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : gen_reg
    logic [XLEN-1:0] q_q;
    assign wr_hot[g] = wr_en_i && (wr_sel_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_q <= '0;
      else if (clr_i)      q_q <= '0;
      else if (wr_hot[g])  q_q <= wr_data_i;
    end
    assign regs_w[g] = q_q;
  end
  assign wr_hot[0] = 1'b0;

  assign rd_a_o = regs_w[rd_a_sel_i];
  assign rd_b_o = regs_w[rd_b_sel_i];
  assign obs0_o = regs_w[OBS0];
  assign obs1_o = regs_w[OBS1];

  assert_zero_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_sel_i == '0) |-> (rd_a_o == '0 && $onehot0(wr_hot)));
  assert_zero_read_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_sel_i == '0) |-> (rd_b_o == '0));
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      op_i,
  output logic [XLEN-1:0] res_o
);
  logic [SHW-1:0] shamt;
  assign shamt = b_i[SHW-1:0];

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_SLL:  res_o = a_i << shamt;
      OP_SRL:  res_o = a_i >> shamt;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i > 3'd4) assert_undef_op_R11: assert (res_o == '0);
  end
endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int OBS0  = 5,
  parameter int OBS1  = 6,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [AW-1:0]   rd_a_sel_i,
  input  logic [AW-1:0]   rd_b_sel_i,
  input  logic [AW-1:0]   wr_sel_i,
  input  logic            wr_en_i,
  input  logic            b_imm_sel_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] obs_t0_o,
  output logic [XLEN-1:0] obs_t1_o
);
  logic [XLEN-1:0] opnd_a, rd_b, opnd_b, alu_res;

  regalu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .OBS0(OBS0), .OBS1(OBS1)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .rd_a_sel_i (rd_a_sel_i),
    .rd_b_sel_i (rd_b_sel_i),
    .wr_sel_i   (wr_sel_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (alu_res),
    .rd_a_o     (opnd_a),
    .rd_b_o     (rd_b),
    .obs0_o     (obs_t0_o),
    .obs1_o     (obs_t1_o)
  );

  assign opnd_b = b_imm_sel_i ? imm_i : rd_b;

  regalu_alu #(.XLEN(XLEN)) u_alu (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .op_i  (op_i),
    .res_o (alu_res)
  );

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (obs_t0_o == '0 && obs_t1_o == '0));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !clr_i) |=> ($stable(obs_t0_o) && $stable(obs_t1_o)));
  assert_write_t0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && wr_sel_i == AW'(OBS0)) |=> (obs_t0_o == $past(alu_res)));
  assert_other_dest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wr_sel_i != AW'(OBS0) && wr_sel_i != AW'(OBS1)) |=> $stable(obs_t0_o));
endmodule

// File: tb/tb_regalu_datapath.sv
module tb_regalu_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [4:0]  ra = '0, rb = '0, rd = '0;
  logic        we = 1'b0, bsel = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] imm = '0;
  logic [63:0] t0, t1;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  regalu_datapath dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .rd_a_sel_i(ra), .rd_b_sel_i(rb),
    .wr_sel_i(rd), .wr_en_i(we), .b_imm_sel_i(bsel), .op_i(op), .imm_i(imm),
    .obs_t0_o(t0), .obs_t1_o(t1)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one instruction per clock: drive at negedge, sample 2 ns after the edge
  task automatic step(logic [2:0] o, logic [4:0] a, logic [4:0] b, logic [4:0] d,
                      logic bs, logic [63:0] im, logic w, logic c);
    @(negedge clk);
    op = o; ra = a; rb = b; rd = d; bsel = bs; imm = im; we = w; clr = c;
    @(posedge clk);
    #2;
    we = 1'b0; clr = 1'b0;
  endtask

  task automatic do_clear();
    step(3'd0, 5'd0, 5'd0, 5'd0, 1'b0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 t0 at reset", t0, 64'd0);
    chk("R1 t1 at reset", t1, 64'd0);
  endtask

  task automatic t_addi();
    do_clear();
    step(3'd0, 5'd5, 5'd0, 5'd5, 1'b1, 64'd1, 1'b1, 1'b0);
    chk("R2 addi x5,x5,1", t0, 64'd1);
    do_clear();
    step(3'd0, 5'd0, 5'd0, 5'd6, 1'b1, 64'd2, 1'b1, 1'b0);
    chk("R3 li x6,2", t1, 64'd2);
    chk("R10 t0 untouched by x6 write", t0, 64'd0);
    do_clear();
    step(3'd0, 5'd5, 5'd0, 5'd5, 1'b1, '1, 1'b1, 1'b0);
    chk("R2 addi x5,x5,-1", t0, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_sub();
    do_clear();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd1, 1'b1, 1'b0);
    step(3'd0, 5'd0, 5'd0, 5'd6, 1'b1, 64'd1, 1'b1, 1'b0);
    chk("R3 li x6,1", t1, 64'd1);
    step(3'd1, 5'd5, 5'd6, 5'd5, 1'b0, 64'd77, 1'b1, 1'b0);
    chk("R4 sub x5,x5,x6", t0, 64'd0);
    step(3'd1, 5'd5, 5'd6, 5'd5, 1'b0, '0, 1'b1, 1'b0);
    chk("R4 sub wraps", t0, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_mul();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd7, 1'b1, 1'b0);
    step(3'd0, 5'd0, 5'd0, 5'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 1'b0);
    step(3'd2, 5'd5, 5'd6, 5'd6, 1'b0, '0, 1'b1, 1'b0);
    chk("R5 mul 7*-3", t1, 64'hFFFF_FFFF_FFFF_FFEB);
  endtask

  task automatic t_shift();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'h8000_0000_0000_0001, 1'b1, 1'b0);
    step(3'd3, 5'd5, 5'd0, 5'd6, 1'b1, 64'd4, 1'b1, 1'b0);
    chk("R6 sll by 4", t1, 64'h10);
    step(3'd4, 5'd5, 5'd0, 5'd5, 1'b1, 64'd63, 1'b1, 1'b0);
    chk("R6 srl by 63 zero fill", t0, 64'd1);
    step(3'd3, 5'd5, 5'd0, 5'd6, 1'b1, 64'd65, 1'b1, 1'b0);
    chk("R6 sll amount masked", t1, 64'd2);
    step(3'd4, 5'd6, 5'd0, 5'd6, 1'b1, 64'hFF00_0000_0000_0041, 1'b1, 1'b0);
    chk("R6 srl amount masked", t1, 64'd1);
  endtask

  task automatic t_no_write();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd99, 1'b0, 1'b0);
    chk("R7 enable low holds t0", t0, 64'd1);
  endtask

  task automatic t_zero_reg();
    step(3'd0, 5'd0, 5'd0, 5'd0, 1'b1, 64'd55, 1'b1, 1'b0);
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd0, 1'b1, 1'b0);
    chk("R8 write to x0 discarded", t0, 64'd0);
    step(3'd0, 5'd0, 5'd0, 5'd6, 1'b1, 64'd12, 1'b1, 1'b0);
    step(3'd0, 5'd6, 5'd0, 5'd5, 1'b0, 64'd500, 1'b1, 1'b0);
    chk("R8 x0 reads zero on port B", t0, 64'd12);
  endtask

  task automatic t_other_reg();
    step(3'd0, 5'd0, 5'd0, 5'd7, 1'b1, 64'd9, 1'b1, 1'b0);
    chk("R10 x7 write leaves t1", t1, 64'd12);
    step(3'd0, 5'd7, 5'd0, 5'd5, 1'b0, '0, 1'b1, 1'b0);
    chk("R10 x7 copied into t0", t0, 64'd9);
  endtask

  task automatic t_clear_wins();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd33, 1'b1, 1'b1);
    chk("R9 clear beats write t0", t0, 64'd0);
    chk("R9 clear t1", t1, 64'd0);
    step(3'd0, 5'd7, 5'd0, 5'd6, 1'b0, '0, 1'b1, 1'b0);
    chk("R9 clear reached x7", t1, 64'd0);
  endtask

  task automatic t_bad_op();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd4, 1'b1, 1'b0);
    step(3'd5, 5'd5, 5'd0, 5'd5, 1'b1, 64'd3, 1'b1, 1'b0);
    chk("R11 op 5 gives 0", t0, 64'd0);
    step(3'd0, 5'd0, 5'd0, 5'd6, 1'b1, 64'd4, 1'b1, 1'b0);
    step(3'd7, 5'd6, 5'd6, 5'd6, 1'b0, '0, 1'b1, 1'b0);
    chk("R11 op 7 gives 0", t1, 64'd0);
  endtask

  task automatic t_async_reset();
    step(3'd0, 5'd0, 5'd0, 5'd5, 1'b1, 64'd21, 1'b1, 1'b0);
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async reset t0", t0, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired, all R checks incomplete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #35;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_addi();
    t_sub();
    t_mul();
    t_shift();
    t_no_write();
    t_zero_reg();
    t_other_reg();
    t_clear_wins();
    t_bad_op();
    t_async_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule